// File: doc/BRIEF.md
# Page Write Buffer and Commit Controller

This block sits behind a serial-bus byte engine in a small nonvolatile storage device. When the bus layer decodes a write command and the two address bytes, it hands the block the starting word address. The block then reads the 64-byte physical page that holds that address from the storage array into a local buffer. Each data byte that follows is stored at the current page offset. Only the low six bits of the word pointer advance, so a long burst wraps back to the start of the same page and overwrites the bytes collected earlier.

A stop condition from the bus layer commits the buffer. The block samples the protect input at that moment. If protection is off and at least one data byte arrived, it writes all 64 bytes of the page back to the array, one byte per clock. Offsets that received no new data get their old contents back, because the buffer was preloaded. It then holds busy until a set number of timer ticks has elapsed. A repeated start, a protected stop or a stop with no data ends the transaction with no array write. The updated pointer is always available to the read path.

Top module: `page_commit_unit`

## Requirements
- R1: After reset, busy, mem_we and mem_re are low and ptr_out is zero.
- R2: An accepted addr_load copies addr_in into ptr_out. Each accepted data byte increments only ptr_out bits [5:0], wrapping 63 to 0, and leaves the upper bits unchanged.
- R3: When more than 64 bytes are sent, a later byte overwrites the earlier byte at the same page offset. After commit, each offset holds the last byte sent to it.
- R4: A transaction ended by abort_strb writes nothing to the array, and busy stays low.
- R5: If wp_in is high in the cycle of stop_strb, nothing is written, busy stays low, and an addr_load in the very next cycle is accepted.
- R6: Changing wp_in after the stop cycle does not affect a write cycle that has already started.
- R7: After a stop that commits, busy is high from the next cycle. It stays high through the 64 write cycles and then until CYCLE_TICKS ticks have been seen in the timing phase. It is low in the cycle after the terminal tick.
- R8: A commit drives exactly 64 consecutive mem_we beats to offsets 0 to 63 of the transaction's page. Offsets that received no byte are rewritten with their previous array contents.
- R9: After a single-byte write, ptr_out points to the next location inside the same page.
- R10: A stop with zero data bytes starts no write cycle, busy stays low, and ptr_out equals the loaded address.
- R11: While busy is high, addr_load and byte_valid are ignored, so ptr_out does not change.
- R12: The page read that follows addr_load takes 64 cycles. A committing stop that arrives during that read raises busy in the next cycle. The write-back then starts once the read completes, and the result is the same as for a later stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_load | input | 1 | Strobe: start a write transaction at addr_in |
| addr_in | input | ADDR_W | Starting word address |
| byte_valid | input | 1 | Strobe: one data byte received |
| byte_data | input | DATA_W | Received data byte |
| stop_strb | input | 1 | Strobe: stop condition ended the transaction |
| abort_strb | input | 1 | Strobe: transaction ended without stop (repeated start) |
| wp_in | input | 1 | Write protect, sampled with stop_strb |
| tick | input | 1 | Time base pulse for the write-cycle timer |
| busy | output | 1 | Internal write cycle in progress or pending |
| mem_re | output | 1 | Array read enable (page preload) |
| mem_raddr | output | ADDR_W | Array read address |
| mem_rdata | input | DATA_W | Array read data, one cycle after mem_re |
| mem_we | output | 1 | Array write enable (page write-back) |
| mem_waddr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |
| ptr_out | output | ADDR_W | Current word pointer |

## Verification
ptr_out reflects a byte or an address load in the cycle after the strobe. busy rises in the cycle after a committing stop. mem_we is then high for exactly the next 64 cycles, and busy falls in the cycle after the tick that completes the count. The bench drives every input on the falling clock edge and samples on the falling edge that follows the rising edge it expects to act. It tracks the tick pulses it generates itself to predict the fall of busy to the exact cycle. When a stop lands inside the 64-cycle preload, the exact start of the write-back is not fixed, so the bench only requires busy in the next cycle, 64 write beats and a correct page.

// File: rtl/pcu_pkg.sv
`timescale 1ns/1ps
package pcu_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_FILL,
        ST_FLUSH,
        ST_WAIT
    } pcu_state_e;

    function automatic logic state_is_busy(input pcu_state_e s);
        return (s == ST_FLUSH) || (s == ST_WAIT);
    endfunction

    function automatic logic state_is_open(input pcu_state_e s);
        return (s == ST_LOAD) || (s == ST_FILL);
    endfunction

endpackage

// File: rtl/pcu_page_store.sv
`timescale 1ns/1ps
module pcu_page_store #(
    parameter int unsigned PAGE_BITS = 6,
    parameter int unsigned DATA_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr_marks,
    input  logic                 host_we,
    input  logic [PAGE_BITS-1:0] host_ofs,
    input  logic [DATA_W-1:0]    host_data,
    input  logic                 fill_we,
    input  logic [PAGE_BITS-1:0] fill_ofs,
    input  logic [DATA_W-1:0]    fill_data,
    input  logic [PAGE_BITS-1:0] rd_ofs,
    output logic [DATA_W-1:0]    rd_data
);
    localparam int unsigned DEPTH = 1 << PAGE_BITS;

    logic [DATA_W-1:0] bytes_q [DEPTH];
    logic [DEPTH-1:0]  marks_q;

    // Preload data never overwrites an offset the host already wrote;
    // a host byte in the same cycle wins on a shared offset.
    always_ff @(posedge clk) begin
        if (fill_we && !marks_q[fill_ofs]) begin
            bytes_q[fill_ofs] <= fill_data;
        end
        if (host_we) begin
            bytes_q[host_ofs] <= host_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr_marks) begin
            marks_q <= '0;
        end else if (host_we) begin
            marks_q[host_ofs] <= 1'b1;
        end
    end

    assign rd_data = bytes_q[rd_ofs];

endmodule

// File: rtl/pcu_cycle_timer.sv
`timescale 1ns/1ps
module pcu_cycle_timer #(
    parameter int unsigned TICKS = 5000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    input  logic tick,
    output logic done
);
    generate
        if (TICKS <= 1) begin : g_direct
            assign done = run && tick;
        end else begin : g_count
            localparam int unsigned CW = $clog2(TICKS);
            localparam logic [CW-1:0] TERM = CW'(TICKS - 1);
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (rst || clear) begin
                    cnt_q <= '0;
                end else if (run && tick) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign done = run && tick && (cnt_q == TERM);
        end
    endgenerate

endmodule

// File: rtl/page_commit_unit.sv
`timescale 1ns/1ps
module page_commit_unit
    import pcu_pkg::*;
#(
    parameter int unsigned ADDR_W      = 15,
    parameter int unsigned PAGE_BITS   = 6,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned CYCLE_TICKS = 5000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              stop_strb,
    input  logic              abort_strb,
    input  logic              wp_in,
    input  logic              tick,
    output logic              busy,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_raddr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [ADDR_W-1:0] ptr_out
);
    localparam int unsigned BASE_W = ADDR_W - PAGE_BITS;
    localparam logic [PAGE_BITS-1:0] LAST_OFS = {PAGE_BITS{1'b1}};

    pcu_state_e           state_q;
    logic [ADDR_W-1:0]    ptr_q;
    logic [BASE_W-1:0]    base_q;
    logic [PAGE_BITS-1:0] ofs_q;
    logic                 have_data_q;
    logic                 pend_q;
    logic                 rd_v_q;
    logic [PAGE_BITS-1:0] rd_ofs_q;
    logic [DATA_W-1:0]    page_rd;

    logic busy_int, open_txn, take_load, take_byte, take_stop, take_abort;
    logic do_commit, last_ofs, timer_done, timer_clear;

    assign busy_int   = state_is_busy(state_q) || pend_q;
    assign open_txn   = state_is_open(state_q) && !pend_q;
    assign take_load  = addr_load && !busy_int;
    assign take_byte  = open_txn && byte_valid && !addr_load;
    assign take_stop  = open_txn && stop_strb && !addr_load;
    assign take_abort = open_txn && abort_strb && !addr_load && !stop_strb;
    assign do_commit  = take_stop && have_data_q && !wp_in;
    assign last_ofs   = (ofs_q == LAST_OFS);
    assign timer_clear = (state_q == ST_FLUSH) && last_ofs;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            ptr_q       <= '0;
            base_q      <= '0;
            ofs_q       <= '0;
            have_data_q <= 1'b0;
            pend_q      <= 1'b0;
            rd_v_q      <= 1'b0;
            rd_ofs_q    <= '0;
        end else begin
            rd_v_q   <= (state_q == ST_LOAD);
            rd_ofs_q <= ofs_q;
            if (take_load) begin
                state_q     <= ST_LOAD;
                ptr_q       <= addr_in;
                base_q      <= addr_in[ADDR_W-1:PAGE_BITS];
                ofs_q       <= '0;
                have_data_q <= 1'b0;
                pend_q      <= 1'b0;
            end else begin
                if (take_byte) begin
                    ptr_q       <= {ptr_q[ADDR_W-1:PAGE_BITS], ptr_q[PAGE_BITS-1:0] + 1'b1};
                    have_data_q <= 1'b1;
                end
                unique case (state_q)
                    ST_LOAD: begin
                        ofs_q <= ofs_q + 1'b1;
                        if (do_commit) begin
                            pend_q <= 1'b1;
                        end
                        if ((take_stop && !do_commit) || take_abort) begin
                            state_q <= ST_IDLE;
                        end else if (last_ofs) begin
                            if (pend_q || do_commit) begin
                                state_q <= ST_FLUSH;
                                pend_q  <= 1'b0;
                            end else begin
                                state_q <= ST_FILL;
                            end
                        end
                    end
                    ST_FILL: begin
                        if (do_commit) begin
                            state_q <= ST_FLUSH;
                            ofs_q   <= '0;
                        end else if (take_stop || take_abort) begin
                            state_q <= ST_IDLE;
                        end
                    end
                    ST_FLUSH: begin
                        ofs_q <= ofs_q + 1'b1;
                        if (last_ofs) begin
                            state_q <= ST_WAIT;
                        end
                    end
                    ST_WAIT: begin
                        if (timer_done) begin
                            state_q <= ST_IDLE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    pcu_page_store #(
        .PAGE_BITS (PAGE_BITS),
        .DATA_W    (DATA_W)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .clr_marks (take_load),
        .host_we   (take_byte),
        .host_ofs  (ptr_q[PAGE_BITS-1:0]),
        .host_data (byte_data),
        .fill_we   (rd_v_q),
        .fill_ofs  (rd_ofs_q),
        .fill_data (mem_rdata),
        .rd_ofs    (ofs_q),
        .rd_data   (page_rd)
    );

    pcu_cycle_timer #(
        .TICKS (CYCLE_TICKS)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clear (timer_clear),
        .run   (state_q == ST_WAIT),
        .tick  (tick),
        .done  (timer_done)
    );

    assign busy      = busy_int;
    assign mem_re    = (state_q == ST_LOAD);
    assign mem_raddr = {base_q, ofs_q};
    assign mem_we    = (state_q == ST_FLUSH);
    assign mem_waddr = {base_q, ofs_q};
    assign mem_wdata = page_rd;
    assign ptr_out   = ptr_q;

endmodule

// File: rtl/pcu_checker.sv
`timescale 1ns/1ps
module pcu_checker #(
    parameter int unsigned ADDR_W    = 15,
    parameter int unsigned PAGE_BITS = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              addr_load,
    input logic              stop_strb,
    input logic              wp_in,
    input logic              busy,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_waddr,
    input logic [ADDR_W-1:0] ptr_out
);
    a_r7_busy_from_stop: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(stop_strb));

    a_r5_wp_blocks_cycle: assert property (@(posedge clk) disable iff (rst)
        (stop_strb && wp_in && !busy) |=> !busy);

    a_r8_write_inside_busy: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);

    a_r8_burst_origin: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !$past(mem_we)) |-> (mem_waddr[PAGE_BITS-1:0] == '0));

    a_r8_burst_order: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |->
            ((mem_waddr[PAGE_BITS-1:0] == $past(mem_waddr[PAGE_BITS-1:0]) + 1'b1) &&
             $stable(mem_waddr[ADDR_W-1:PAGE_BITS])));

    a_r2_upper_bits_held: assert property (@(posedge clk) disable iff (rst)
        !$past(addr_load) |-> $stable(ptr_out[ADDR_W-1:PAGE_BITS]));

    a_r11_busy_freezes_ptr: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(ptr_out));

endmodule

bind page_commit_unit pcu_checker #(
    .ADDR_W    (ADDR_W),
    .PAGE_BITS (PAGE_BITS)
) u_pcu_chk (
    .clk       (clk),
    .rst       (rst),
    .addr_load (addr_load),
    .stop_strb (stop_strb),
    .wp_in     (wp_in),
    .busy      (busy),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .ptr_out   (ptr_out)
);

// File: tb/tb_page_commit_unit.sv
`timescale 1ns/1ps
module tb_page_commit_unit;
    localparam int AW = 10;
    localparam int PB = 6;
    localparam int DW = 8;
    localparam int TK = 4;
    localparam int MEMSZ = 1 << AW;
    localparam int PG = 1 << PB;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic addr_load = 0, byte_valid = 0, stop_strb = 0, abort_strb = 0, wp_in = 0, tick = 0;
    logic [AW-1:0] addr_in = '0;
    logic [DW-1:0] byte_data = '0;
    logic busy, mem_re, mem_we;
    logic [AW-1:0] mem_raddr, mem_waddr, ptr_out;
    logic [DW-1:0] mem_rdata, mem_wdata;

    page_commit_unit #(
        .ADDR_W(AW), .PAGE_BITS(PB), .DATA_W(DW), .CYCLE_TICKS(TK)
    ) dut (
        .clk(clk), .rst(rst), .addr_load(addr_load), .addr_in(addr_in),
        .byte_valid(byte_valid), .byte_data(byte_data), .stop_strb(stop_strb),
        .abort_strb(abort_strb), .wp_in(wp_in), .tick(tick), .busy(busy),
        .mem_re(mem_re), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .ptr_out(ptr_out)
    );

    function automatic logic [DW-1:0] init_val(input int a);
        return DW'((a * 37 + 11) ^ (a >> 3));
    endfunction

    // Array model: synchronous RAM with one-cycle read latency
    logic [DW-1:0] mem [MEMSZ];
    logic [DW-1:0] shadow [MEMSZ];
    int we_cnt = 0;
    int page_err = 0;
    int exp_page = 0;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEMSZ; i++) mem[i] <= init_val(i);
        end else begin
            if (mem_re) mem_rdata <= mem[mem_raddr];
            if (mem_we) begin
                mem[mem_waddr] <= mem_wdata;
                we_cnt <= we_cnt + 1;
                if (int'(mem_waddr >> PB) != exp_page) page_err <= page_err + 1;
            end
        end
    end

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit finished = 0;

    task automatic step();
        @(negedge clk);
        cyc++;
        tick = (cyc % 7 == 0);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int page_mismatch(input int page);
        int m = 0;
        for (int i = 0; i < PG; i++) if (mem[page * PG + i] !== shadow[page * PG + i]) m++;
        return m;
    endfunction

    // ending: 0 = stop, 1 = abort
    task automatic run_txn(input int addr, input int nbytes, input int pre_gap, input int ending,
                           input bit wp_stop, input bit wp_flip, input bit poke, input string preq);
        logic [DW-1:0] sent [128];
        int page, lo, exp_ptr, we0, ld_cyc, k, ticks, bad_we, bad_busy;
        bit precise, fin, commit;
        page = addr / PG;
        lo = addr % PG;
        exp_ptr = addr;
        step();
        addr_load = 1; addr_in = AW'(addr); ld_cyc = cyc;
        step();
        addr_load = 0;
        chk(ptr_out == AW'(addr), "R2", "pointer after load", ptr_out, addr);
        repeat (pre_gap) step();
        for (int i = 0; i < nbytes; i++) begin
            sent[i] = DW'($urandom);
            byte_valid = 1; byte_data = sent[i];
            step();
            byte_valid = 0;
            exp_ptr = page * PG + (lo + i + 1) % PG;
            repeat ($urandom % 3) step();
        end
        chk(ptr_out == AW'(exp_ptr), (nbytes == 1) ? "R9" : "R2", "pointer after bytes", ptr_out, exp_ptr);
        exp_page = page;
        we0 = we_cnt;
        if (ending == 1) begin
            abort_strb = 1;
            step();
            abort_strb = 0;
            chk(busy == 0, "R4", "busy after abort", busy, 0);
            repeat (70) step();
            chk(we_cnt == we0, "R4", "writes after abort", we_cnt - we0, 0);
            chk(page_mismatch(page) == 0, "R4", "page after abort", page_mismatch(page), 0);
            return;
        end
        precise = (cyc >= ld_cyc + 65);
        commit = (nbytes > 0) && !wp_stop;
        stop_strb = 1; wp_in = wp_stop;
        step();
        stop_strb = 0;
        if (wp_flip) wp_in = ~wp_stop;
        if (!commit) begin
            chk(busy == 0, wp_stop ? "R5" : "R10", "busy after stop", busy, 0);
            if (wp_stop) begin
                addr_load = 1; addr_in = AW'(addr ^ 7);
                step();
                addr_load = 0;
                chk(ptr_out == AW'(addr ^ 7), "R5", "load right after protected stop", ptr_out, addr ^ 7);
                abort_strb = 1;
                step();
                abort_strb = 0;
            end else begin
                chk(ptr_out == AW'(addr), "R10", "pointer with no data", ptr_out, addr);
            end
            repeat (70) step();
            chk(we_cnt == we0, wp_stop ? "R5" : "R10", "array writes", we_cnt - we0, 0);
            chk(busy == 0, wp_stop ? "R5" : "R10", "busy stays low", busy, 0);
            chk(page_mismatch(page) == 0, wp_stop ? "R5" : "R10", "page untouched", page_mismatch(page), 0);
            wp_in = 0;
            return;
        end
        for (int i = 0; i < nbytes; i++) shadow[page * PG + (lo + i) % PG] = sent[i];
        if (precise) begin
            k = 0; ticks = 0; fin = 0; bad_we = 0; bad_busy = 0;
            while (!fin && k < 2000) begin
                k++;
                if (k > 1) step();
                if (mem_we !== (k <= 64)) bad_we++;
                if (busy !== 1'b1) bad_busy++;
                if (k >= 65 && tick) begin
                    ticks++;
                    if (ticks == TK) fin = 1;
                end
                if (poke) begin
                    if (k == 70) begin addr_load = 1; addr_in = AW'(addr + 200); end
                    if (k == 71) begin addr_load = 0; byte_valid = 1; byte_data = 8'hA5; end
                    if (k == 72) byte_valid = 0;
                end
            end
            addr_load = 0; byte_valid = 0;
            chk(bad_we == 0, "R8", "write strobe cycles", bad_we, 0);
            chk(bad_busy == 0, "R7", "busy held during cycle", bad_busy, 0);
            step();
            chk(busy == 0, "R7", "busy after terminal tick", busy, 0);
        end else begin
            chk(busy == 1, "R12", "busy after stop during preload", busy, 1);
            k = 0;
            while (busy && k < 2000) begin step(); k++; end
        end
        wp_in = 0;
        chk(we_cnt - we0 == PG, precise ? "R8" : "R12", "write beat count", we_cnt - we0, PG);
        chk(page_err == 0, "R8", "write beats outside page", page_err, 0);
        chk(page_mismatch(page) == 0, preq, "committed page contents", page_mismatch(page), 0);
        chk(ptr_out == AW'(exp_ptr), "R11", "pointer after cycle", ptr_out, exp_ptr);
    endtask

    initial begin
        void'($urandom(32'd1357));
        for (int i = 0; i < MEMSZ; i++) shadow[i] = init_val(i);
        repeat (3) step();
        rst = 0;
        step();
        chk(busy == 0, "R1", "busy after reset", busy, 0);
        chk(mem_we == 0 && mem_re == 0, "R1", "array strobes after reset", {mem_we, mem_re}, 0);
        chk(ptr_out == 0, "R1", "pointer after reset", ptr_out, 0);

        run_txn(10'h13F, 1, 70, 0, 0, 0, 0, "R9");
        run_txn(10'h155, 1, 70, 0, 0, 0, 0, "R8");
        run_txn(10'h20A, 70, 68, 0, 0, 0, 1, "R3");
        run_txn(10'h280, 3, 0, 0, 0, 0, 0, "R12");
        run_txn(10'h0C4, 5, 68, 0, 1, 0, 0, "R5");
        run_txn(10'h311, 6, 68, 0, 0, 1, 0, "R6");
        run_txn(10'h333, 0, 68, 0, 0, 0, 0, "R10");
        run_txn(10'h1A0, 4, 68, 1, 0, 0, 0, "R4");
        for (int t = 0; t < 6; t++) begin
            run_txn(int'($urandom % MEMSZ), 1 + int'($urandom % 80), 66 + int'($urandom % 10),
                    0, 0, 0, 0, "R8");
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule